// File: doc/BRIEF.md
# Security Code Attempt-Limited Validator

This block guards access behind a 16-bit secret that a host proves by clocking it past the memory one bit at a time. A separate access sequencer decodes the card's pad activity into single-cycle events and provides them to this block. The events are a card reset, a per-bit compare with its mismatch result, a program-0 request, an erase request, a rising edge of the programming pin, and a clock rise seen while the programming pin was low. With those events the sequencer also supplies the current bit address, the readback of the addressed memory bit, and the first four bits of the attempts counter.

The block requires the host to spend one attempt before it learns anything. After the 16 compares over the code window, the host programs a 0 into the first attempts bit that still holds 1. Only then does a rising edge of the programming pin grant validation. The grant depends on three things: all sixteen bits compared equal, the programmed bit reads back 0, and the device is not locked. Once validation is granted, an erase of the attempts counter is let through, which restores the spent attempt. When the first four attempts bits are all 0, the device is locked and no later attempt can succeed.

Top module: `sec_code_guard`

## Requirements
- R1: After `rst`, `validated`, `locked`, `prog_stb` and `erase_stb` are all 0.
- R2: The code counts as matched only after exactly 16 `ev_cmp` events at addresses 80 to 95 since the last `ev_reset`, none of them with `cmp_miss` high. An `ev_cmp` at an address outside 80 to 95 has no effect.
- R3: An `ev_prog` at an address from 96 to 99 (the first four attempts bits) while not locked raises `prog_stb` for exactly the following cycle and arms the block. An `ev_prog` at any other address gives no strobe and does not arm.
- R4: An `ev_pgm_rise` while armed, with the code matched, `rd_bit` at 0 and not locked, sets `validated` in the following cycle. Every `ev_pgm_rise` disarms the block.
- R5: An `ev_clk_abort` disarms the block. When it arrives in the same cycle as `ev_pgm_rise`, validation is not granted.
- R6: If `rd_bit` is 1 at the `ev_pgm_rise` (the programmed 0 did not stick), validation is not granted.
- R7: When `tries_bits` is all zero, `locked` rises in the following cycle and stays 1 until `rst`. While locked, `ev_prog` gives no strobe and validation is never granted.
- R8: An `ev_erase` at an address from 96 to 111 while `validated` is 1 raises `erase_stb` for the following cycle. Any other `ev_erase` is ignored.
- R9: `ev_reset` clears `validated`, the arming and the compare progress. It wins over an `ev_pgm_rise` in the same cycle.
- R10: An `ev_pgm_rise` without a prior accepted `ev_prog` does not grant validation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| ev_reset | input | 1 | Card reset event (address counter returned to 0) |
| ev_cmp | input | 1 | Compare step at `addr` |
| ev_prog | input | 1 | Program-0 request at `addr` |
| ev_erase | input | 1 | Erase request at `addr` |
| ev_pgm_rise | input | 1 | Rising edge of the programming pin |
| ev_clk_abort | input | 1 | Clock rose while the programming pin was low |
| cmp_miss | input | 1 | Presented bit differed from the stored bit (valid with `ev_cmp`) |
| addr | input | 11 | Current bit address |
| rd_bit | input | 1 | Readback of the addressed memory bit |
| tries_bits | input | 4 | First four bits of the attempts counter |
| validated | output | 1 | Security code accepted |
| locked | output | 1 | All four attempts spent |
| prog_stb | output | 1 | Program-0 strobe to the addressed attempts bit |
| erase_stb | output | 1 | Erase strobe to the attempts counter |

## Verification
Two pairs of events can land in the same cycle. In the first pair, a card reset arrives together with the programming-pin rise that would grant validation. In the second, a clock-abort arrives together with that rise. The bench runs a complete, otherwise valid attempt, then drives both events of a pair on one clock edge and checks that `validated` stays 0. It also checks that a card reset clears a flag that was already granted, and that once the flag is cleared an erase request no longer produces a strobe.

// File: rtl/sec_code_pkg.sv
package sec_code_pkg;

    localparam int unsigned ADDR_W_D    = 11;
    localparam int unsigned CODE_BASE_D = 80;
    localparam int unsigned CODE_LEN_D  = 16;
    localparam int unsigned ATT_BASE_D  = 96;
    localparam int unsigned ATT_LEN_D   = 16;
    localparam int unsigned ATT_TRIES_D = 4;

    // One-cycle events delivered by the access sequencer
    typedef struct packed {
        logic card_reset;
        logic cmp;
        logic prog;
        logic erase;
        logic pgm_rise;
        logic clk_abort;
    } seq_ev_t;

    function automatic logic in_window(input logic [31:0] a,
                                       input logic [31:0] base,
                                       input logic [31:0] len);
        return (a >= base) && (a < base + len);
    endfunction

endpackage

// File: rtl/sc_cmp_track.sv
module sc_cmp_track
    import sec_code_pkg::*;
#(
    parameter int unsigned ADDR_W    = ADDR_W_D,
    parameter int unsigned CODE_BASE = CODE_BASE_D,
    parameter int unsigned CODE_LEN  = CODE_LEN_D
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_ev_t           ev,
    input  logic              cmp_miss,
    input  logic [ADDR_W-1:0] addr,
    output logic              code_ok
);
    localparam int unsigned CW = $clog2(CODE_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(CODE_LEN);

    logic [CW-1:0] seen_q;
    logic          miss_q;
    logic          in_code;

    assign in_code = in_window(32'(addr), CODE_BASE, CODE_LEN);

    always_ff @(posedge clk) begin
        if (rst || ev.card_reset) begin
            seen_q <= '0;
            miss_q <= 1'b0;
        end else if (ev.cmp && in_code) begin
            if (seen_q != FULL) seen_q <= seen_q + 1'b1;
            miss_q <= miss_q | cmp_miss;
        end
    end

    assign code_ok = (seen_q == FULL) && !miss_q;

    // R2
    code_ok_after_cmp_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(code_ok) |-> $past(ev.cmp));

endmodule

// File: rtl/sc_lock_mon.sv
module sc_lock_mon
    import sec_code_pkg::*;
#(
    parameter int unsigned ATT_TRIES = ATT_TRIES_D
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ATT_TRIES-1:0] tries_bits,
    output logic                 locked
);
    always_ff @(posedge clk) begin
        if (rst)                   locked <= 1'b0;
        else if (tries_bits == '0) locked <= 1'b1;
    end

    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

endmodule

// File: rtl/sc_attempt_ctl.sv
module sc_attempt_ctl
    import sec_code_pkg::*;
#(
    parameter int unsigned ADDR_W    = ADDR_W_D,
    parameter int unsigned ATT_BASE  = ATT_BASE_D,
    parameter int unsigned ATT_LEN   = ATT_LEN_D,
    parameter int unsigned ATT_TRIES = ATT_TRIES_D
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_ev_t           ev,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_bit,
    input  logic              code_ok,
    input  logic              locked,
    output logic              validated,
    output logic              prog_stb,
    output logic              erase_stb
);
    logic armed_q;
    logic in_try, in_att, grant;

    assign in_try = in_window(32'(addr), ATT_BASE, ATT_TRIES);
    assign in_att = in_window(32'(addr), ATT_BASE, ATT_LEN);
    assign grant  = ev.pgm_rise && armed_q && !ev.clk_abort
                    && !rd_bit && code_ok && !locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            validated <= 1'b0;
            armed_q   <= 1'b0;
            prog_stb  <= 1'b0;
            erase_stb <= 1'b0;
        end else begin
            prog_stb  <= 1'b0;
            erase_stb <= 1'b0;
            if (ev.card_reset) begin
                validated <= 1'b0;
                armed_q   <= 1'b0;
            end else begin
                if (ev.prog && in_try && !locked) begin
                    prog_stb <= 1'b1;
                    armed_q  <= 1'b1;
                end
                if (ev.pgm_rise || ev.clk_abort) armed_q <= 1'b0;
                if (grant) validated <= 1'b1;
                if (ev.erase && in_att && validated) erase_stb <= 1'b1;
            end
        end
    end

    // R4
    grant_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(validated) |-> $past(ev.pgm_rise && code_ok && !rd_bit));
    // R5
    abort_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.clk_abort && !validated) |=> !validated);
    // R7
    locked_no_prog_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> !prog_stb);
    // R8
    erase_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        erase_stb |-> $past(validated));
    // R9
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ev.card_reset |=> !validated);

endmodule

// File: rtl/sec_code_guard.sv
module sec_code_guard
    import sec_code_pkg::*;
#(
    parameter int unsigned ADDR_W    = ADDR_W_D,
    parameter int unsigned CODE_BASE = CODE_BASE_D,
    parameter int unsigned CODE_LEN  = CODE_LEN_D,
    parameter int unsigned ATT_BASE  = ATT_BASE_D,
    parameter int unsigned ATT_LEN   = ATT_LEN_D,
    parameter int unsigned ATT_TRIES = ATT_TRIES_D
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ev_reset,
    input  logic                 ev_cmp,
    input  logic                 ev_prog,
    input  logic                 ev_erase,
    input  logic                 ev_pgm_rise,
    input  logic                 ev_clk_abort,
    input  logic                 cmp_miss,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rd_bit,
    input  logic [ATT_TRIES-1:0] tries_bits,
    output logic                 validated,
    output logic                 locked,
    output logic                 prog_stb,
    output logic                 erase_stb
);
    seq_ev_t ev;
    logic    code_ok;

    assign ev = '{card_reset: ev_reset, cmp: ev_cmp, prog: ev_prog,
                  erase: ev_erase, pgm_rise: ev_pgm_rise,
                  clk_abort: ev_clk_abort};

    sc_cmp_track #(.ADDR_W(ADDR_W), .CODE_BASE(CODE_BASE), .CODE_LEN(CODE_LEN))
    u_cmp (
        .clk(clk), .rst(rst), .ev(ev), .cmp_miss(cmp_miss),
        .addr(addr), .code_ok(code_ok)
    );

    sc_lock_mon #(.ATT_TRIES(ATT_TRIES)) u_lock (
        .clk(clk), .rst(rst), .tries_bits(tries_bits), .locked(locked)
    );

    sc_attempt_ctl #(.ADDR_W(ADDR_W), .ATT_BASE(ATT_BASE),
                     .ATT_LEN(ATT_LEN), .ATT_TRIES(ATT_TRIES))
    u_ctl (
        .clk(clk), .rst(rst), .ev(ev), .addr(addr), .rd_bit(rd_bit),
        .code_ok(code_ok), .locked(locked), .validated(validated),
        .prog_stb(prog_stb), .erase_stb(erase_stb)
    );

endmodule

// File: tb/sec_code_guard_tb.sv
module sec_code_guard_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst, ev_reset, ev_cmp, ev_prog, ev_erase, ev_pgm_rise, ev_clk_abort;
    logic cmp_miss, rd_bit;
    logic [10:0] addr;
    logic [3:0]  tries_bits;
    logic validated, locked, prog_stb, erase_stb;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_code_guard u_dut (
        .clk(clk), .rst(rst), .ev_reset(ev_reset), .ev_cmp(ev_cmp),
        .ev_prog(ev_prog), .ev_erase(ev_erase), .ev_pgm_rise(ev_pgm_rise),
        .ev_clk_abort(ev_clk_abort), .cmp_miss(cmp_miss), .addr(addr),
        .rd_bit(rd_bit), .tries_bits(tries_bits), .validated(validated),
        .locked(locked), .prog_stb(prog_stb), .erase_stb(erase_stb)
    );

    // [7:3] mismatch position (16 = none), [2] readback, [1] abort, [0] expected grant
    localparam logic [7:0] VEC [8] = '{
        {5'd16, 1'b0, 1'b0, 1'b1},
        {5'd0,  1'b0, 1'b0, 1'b0},
        {5'd15, 1'b0, 1'b0, 1'b0},
        {5'd7,  1'b0, 1'b0, 1'b0},
        {5'd16, 1'b1, 1'b0, 1'b0},
        {5'd16, 1'b0, 1'b1, 1'b0},
        {5'd3,  1'b1, 1'b0, 1'b0},
        {5'd16, 1'b0, 1'b0, 1'b1}
    };

    task automatic check(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clr_ev();
        ev_reset = 0; ev_cmp = 0; ev_prog = 0; ev_erase = 0;
        ev_pgm_rise = 0; ev_clk_abort = 0; cmp_miss = 0;
    endtask

    // card reset plus n compares over the code window
    task automatic code_seq(input int miss_pos, input int n);
        ev_reset = 1; tick(); clr_ev();
        for (int i = 0; i < n; i++) begin
            addr = 11'(80 + i); cmp_miss = (i == miss_pos); ev_cmp = 1;
            tick(); clr_ev();
        end
    endtask

    task automatic prog_at(input int a);
        addr = 11'(a); ev_prog = 1; tick(); clr_ev();
    endtask

    task automatic pgm_rise(input logic rb);
        rd_bit = rb; ev_pgm_rise = 1; tick(); clr_ev();
    endtask

    task automatic erase_at(input int a);
        addr = 11'(a); ev_erase = 1; tick(); clr_ev();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        clr_ev(); addr = '0; rd_bit = 0; tries_bits = 4'b1111; rst = 1;
        tick(); tick(); rst = 0; tick();
        check("R1 validated", validated, 0);
        check("R1 locked", locked, 0);
        check("R1 prog_stb", prog_stb, 0);
        check("R1 erase_stb", erase_stb, 0);

        foreach (VEC[k]) begin
            code_seq(int'(VEC[k][7:3]), 16);
            prog_at(96);
            check("R3 prog_stb at 96", prog_stb, 1);
            tick();
            check("R3 prog_stb one cycle", prog_stb, 0);
            if (VEC[k][1]) begin
                ev_clk_abort = 1; tick(); clr_ev();
            end
            pgm_rise(VEC[k][2]);
            check("R2/R4/R5/R6 table grant", validated, VEC[k][0]);
            erase_at(100);
            check("R8 erase follows grant", erase_stb, VEC[k][0]);
            check("R4 flag held after erase", validated, VEC[k][0]);
        end

        // R2: compare outside the window is ignored
        code_seq(99, 16);
        addr = 11'd50; cmp_miss = 1; ev_cmp = 1; tick(); clr_ev();
        prog_at(97); pgm_rise(0);
        check("R2 out-of-window compare ignored", validated, 1);
        // R8: erase outside attempts field ignored even when validated
        erase_at(50);
        check("R8 erase at 50 ignored", erase_stb, 0);
        // R9: card reset clears granted flag, erase then refused
        ev_reset = 1; tick(); clr_ev();
        check("R9 reset clears validated", validated, 0);
        erase_at(96);
        check("R8 erase refused after reset", erase_stb, 0);

        // R2: only 15 compares
        code_seq(99, 15); prog_at(96); pgm_rise(0);
        check("R2 short compare", validated, 0);

        // R10: rise without program
        code_seq(99, 16); pgm_rise(0);
        check("R10 no prog no grant", validated, 0);

        // R3: program outside first four attempts bits
        code_seq(99, 16); prog_at(100);
        check("R3 no strobe at 100", prog_stb, 0);
        pgm_rise(0);
        check("R3 not armed at 100", validated, 0);
        prog_at(99);
        check("R3 strobe at 99", prog_stb, 1);

        // R9: reset and rise in same cycle
        code_seq(99, 16); prog_at(98);
        rd_bit = 0; ev_pgm_rise = 1; ev_reset = 1; tick(); clr_ev();
        check("R9 reset beats rise", validated, 0);

        // R5: abort and rise in same cycle
        code_seq(99, 16); prog_at(98);
        rd_bit = 0; ev_pgm_rise = 1; ev_clk_abort = 1; tick(); clr_ev();
        check("R5 abort beats rise", validated, 0);

        // R7: lock
        tries_bits = 4'b0000; tick();
        check("R7 locked rises", locked, 1);
        tries_bits = 4'b1111; tick(); tick();
        check("R7 locked sticky", locked, 1);
        code_seq(99, 16); prog_at(96);
        check("R7 no strobe when locked", prog_stb, 0);
        pgm_rise(0);
        check("R7 no grant when locked", validated, 0);
        rst = 1; tick(); rst = 0; tick();
        check("R1 rst clears lock", locked, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule